// File: doc/BRIEF.md
# Shared-Bus Multi-Master Arbiter

This block decides which of four bus masters may drive a shared pipelined system bus. Each master raises its own request line and may also hold a lock line to mark an atomic sequence, such as a read-modify-write. The arbiter registers a one-hot grant that names the next master to own the bus. The owner number then follows that grant, but only at a completed transfer boundary. A burst that is still running is never split, and no handover takes place while the owner holds a lock.

The grant leads ownership by at least one cycle, so a master learns that it is next before it has to drive. A two-bit policy input selects how the next master is chosen. Fixed priority favours the lowest index. Round-robin searches onward from the current owner. Priority with aging lets a long-waiting requester overtake fixed priority once its wait counter has saturated at a threshold set by an input. When nobody requests, master 0 is parked on the bus.

Top module: `mm_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, the grant is 4'b0001, the owner number is 0 and the lock output is 0.
- R2: The grant output is one-hot in every cycle.
- R3: When no request and no lock line is high, the grant on the following cycle is 4'b0001 (master 0 parked).
- R4: With policy 2'b00 (fixed) and no lock in force, the registered grant one cycle later names the lowest-index requester.
- R5: With policy 2'b01 (round-robin), the search starts at the index just after the current owner and wraps around. A master that keeps requesting becomes owner before more than N-1 ownership changes go to other requesting masters.
- R6: Each master has a wait counter that counts up each cycle the master requests while not owning the bus, holds at the threshold input, and clears when the master stops requesting or owns the bus. With policy 2'b10 (aging), the lowest-index requester whose counter has reached the threshold is granted ahead of fixed priority.
- R7: The owner number changes only on an edge where hready is high and either htrans is 2'b00 (idle) or burst_last is high. Mid-burst, the owner is held.
- R8: A master that becomes owner held the grant in the cycle before that edge, so the grant leads ownership.
- R9: The lock output equals the lock line of the master that owns the bus after each edge. While it is high, the grant stays on the owner and ownership cannot move.
- R10: Policy code 2'b11 selects the same behaviour as fixed priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Per-master bus request |
| lock_i | input | 4 | Per-master lock request |
| htrans_i | input | 2 | Transfer type of the current bus cycle, 2'b00 is idle |
| burst_last_i | input | 1 | Current beat is the last of its burst |
| hready_i | input | 1 | Current transfer completes this cycle |
| policy_i | input | 2 | Grant policy: 00 fixed, 01 round-robin, 10 aging, 11 fixed |
| age_limit_i | input | 4 | Wait-counter saturation threshold for aging |
| grant_o | output | 4 | One-hot registered grant |
| owner_o | output | 2 | Index of the master that currently owns the bus |
| owner_lock_o | output | 1 | The owner holds a locked sequence |

## Verification
The two functions most likely to meet in one cycle are the handover and the lock capture. An owner can raise its lock on the very edge where a transfer boundary would move the bus to the master already granted. A newly arriving owner can also bring its lock line high on the handover edge itself. Random stimulus toggles lock lines independently of boundaries, and a directed sequence raises the lock of an owner while a higher-priority master requests. A cycle-accurate bench model judges the outcome: it decides the next owner before it captures the lock, so the grant and the owner must agree whenever the lock output is high.

// File: rtl/mm_arb_pkg.sv
package mm_arb_pkg;

  typedef enum logic [1:0] {
    POL_FIXED = 2'b00,
    POL_RR    = 2'b01,
    POL_AGE   = 2'b10,
    POL_SPARE = 2'b11
  } arb_policy_e;

  localparam logic [1:0] HTRANS_IDLE = 2'b00;

endpackage

// File: rtl/mm_arb_select.sv
// Combinational winner selection for the three policies (R4, R5, R6, R10).
module mm_arb_select
  import mm_arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  aged_i,
  input  logic [IW-1:0] last_owner_i,
  input  logic [1:0]    policy_i,
  output logic [IW-1:0] pick_idx_o
);

  function automatic logic [IW-1:0] lowest_set(input logic [N-1:0] v);
    lowest_set = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (v[k]) lowest_set = IW'(k);
    end
  endfunction

  // search from last+1 upward, wrapping; smallest offset wins
  function automatic logic [IW-1:0] rr_next(input logic [N-1:0] v,
                                            input logic [IW-1:0] last);
    int idx;
    rr_next = '0;
    for (int k = N; k >= 1; k--) begin
      idx = (int'(last) + k) % N;
      if (v[idx[IW-1:0]]) rr_next = IW'(idx);
    end
  endfunction

  arb_policy_e pol;
  logic [N-1:0] aged_req;

  assign pol      = arb_policy_e'(policy_i);
  assign aged_req = req_i & aged_i;

  always_comb begin
    unique case (pol)
      POL_RR:  pick_idx_o = rr_next(req_i, last_owner_i);
      POL_AGE: pick_idx_o = (|aged_req) ? lowest_set(aged_req) : lowest_set(req_i);
      default: pick_idx_o = lowest_set(req_i); // R10: spare code acts as fixed
    endcase
  end

endmodule

// File: rtl/mm_arb_age.sv
// Per-master saturating wait counters (R6).
module mm_arb_age #(
  parameter int N  = 4,
  parameter int IW = 2,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] owner_i,
  input  logic [AW-1:0] limit_i,
  output logic [N-1:0]  aged_o
);

  for (genvar m = 0; m < N; m++) begin : g_wait
    logic [AW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (!req_i[m] || owner_i == IW'(m)) begin
        cnt_q <= '0;
      end else if (cnt_q < limit_i) begin
        cnt_q <= cnt_q + AW'(1);
      end
    end

    assign aged_o[m] = (cnt_q >= limit_i);
  end

endmodule

// File: rtl/mm_arb_owner.sv
// Grant register, ownership handover at boundaries, lock capture (R7, R8, R9).
module mm_arb_owner
  import mm_arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  lock_i,
  input  logic [1:0]    htrans_i,
  input  logic          burst_last_i,
  input  logic          hready_i,
  input  logic [IW-1:0] pick_idx_i,
  output logic [N-1:0]  grant_q,
  output logic [IW-1:0] owner_q,
  output logic          owner_lock_q,
  output logic          handover_o
);

  function automatic logic [IW-1:0] enc(input logic [N-1:0] v);
    enc = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (v[k]) enc = IW'(k);
    end
  endfunction

  logic          xfer_boundary;
  logic [IW-1:0] grant_idx;
  logic [IW-1:0] owner_d;
  logic          lock_d;
  logic [N-1:0]  grant_d;

  // a completed transfer with no burst still running
  assign xfer_boundary = hready_i && (htrans_i == HTRANS_IDLE || burst_last_i);
  assign grant_idx     = enc(grant_q);
  assign handover_o    = xfer_boundary && !owner_lock_q && (grant_idx != owner_q);
  assign owner_d       = handover_o ? grant_idx : owner_q;
  assign lock_d        = lock_i[owner_d];
  // a lock on the owner-to-be pins the grant to it
  assign grant_d       = lock_d ? (N'(1) << owner_d) : (N'(1) << pick_idx_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q      <= N'(1);
      owner_q      <= '0;
      owner_lock_q <= 1'b0;
    end else begin
      grant_q      <= grant_d;
      owner_q      <= owner_d;
      owner_lock_q <= lock_d;
    end
  end

endmodule

// File: rtl/mm_arbiter.sv
module mm_arbiter
  import mm_arb_pkg::*;
#(
  parameter int  MASTERS  = 4,
  parameter int  AGE_W    = 4,
  parameter bit  AGING_EN = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [MASTERS-1:0]         req_i,
  input  logic [MASTERS-1:0]         lock_i,
  input  logic [1:0]                 htrans_i,
  input  logic                       burst_last_i,
  input  logic                       hready_i,
  input  logic [1:0]                 policy_i,
  input  logic [AGE_W-1:0]           age_limit_i,
  output logic [MASTERS-1:0]         grant_o,
  output logic [$clog2(MASTERS)-1:0] owner_o,
  output logic                       owner_lock_o
);

  localparam int IDX_W = $clog2(MASTERS);

  logic [MASTERS-1:0] aged;
  logic [IDX_W-1:0]   pick_idx;
  logic               handover;

  if (AGING_EN) begin : g_aging
    mm_arb_age #(.N(MASTERS), .IW(IDX_W), .AW(AGE_W)) u_age (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req_i),
      .owner_i (owner_o),
      .limit_i (age_limit_i),
      .aged_o  (aged)
    );
  end else begin : g_no_aging
    logic unused_limit;
    assign unused_limit = ^age_limit_i;
    assign aged         = '0;
  end

  mm_arb_select #(.N(MASTERS), .IW(IDX_W)) u_sel (
    .req_i        (req_i),
    .aged_i       (aged),
    .last_owner_i (owner_o),
    .policy_i     (policy_i),
    .pick_idx_o   (pick_idx)
  );

  mm_arb_owner #(.N(MASTERS), .IW(IDX_W)) u_own (
    .clk          (clk),
    .rst_n        (rst_n),
    .lock_i       (lock_i),
    .htrans_i     (htrans_i),
    .burst_last_i (burst_last_i),
    .hready_i     (hready_i),
    .pick_idx_i   (pick_idx),
    .grant_q      (grant_o),
    .owner_q      (owner_o),
    .owner_lock_q (owner_lock_o),
    .handover_o   (handover)
  );

endmodule

// File: rtl/mm_arb_chk.sv
module mm_arb_chk #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req_i,
  input logic [N-1:0]  lock_i,
  input logic [1:0]    htrans_i,
  input logic          burst_last_i,
  input logic          hready_i,
  input logic [N-1:0]  grant_o,
  input logic [IW-1:0] owner_o,
  input logic          owner_lock_o,
  input logic          handover
);

  logic [N-1:0] own_oh;
  logic         bnd;

  assign own_oh = N'(1) << owner_o;
  assign bnd    = hready_i && (htrans_i == 2'b00 || burst_last_i);

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant_o) == 1);

  // R3
  idle_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0 && lock_i == '0) |=> grant_o == N'(1));

  // R7
  owner_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(owner_o) |-> $past(bnd));

  // R8
  grant_leads_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(owner_o) |-> $past(grant_o) == own_oh);

  // R9
  lock_pins_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owner_lock_o |-> grant_o == own_oh);

  // R9
  lock_blocks_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owner_lock_o |-> !handover);

  // R9
  lock_holds_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(owner_lock_o) |-> $stable(owner_o));

endmodule

bind mm_arbiter mm_arb_chk #(.N(MASTERS), .IW(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_i        (req_i),
  .lock_i       (lock_i),
  .htrans_i     (htrans_i),
  .burst_last_i (burst_last_i),
  .hready_i     (hready_i),
  .grant_o      (grant_o),
  .owner_o      (owner_o),
  .owner_lock_o (owner_lock_o),
  .handover     (handover)
);

// File: tb/mm_arbiter_tb.sv
module mm_arbiter_tb;

  localparam int N  = 4;
  localparam int IW = 2;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [N-1:0]  req, lock;
  logic [1:0]    htrans, policy;
  logic          blast, hready;
  logic [AW-1:0] limit;
  logic [N-1:0]  grant;
  logic [IW-1:0] owner;
  logic          olock;

  int checks = 0;
  int fails  = 0;

  mm_arbiter #(.MASTERS(N), .AGE_W(AW)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req),
    .lock_i       (lock),
    .htrans_i     (htrans),
    .burst_last_i (blast),
    .hready_i     (hready),
    .policy_i     (policy),
    .age_limit_i  (limit),
    .grant_o      (grant),
    .owner_o      (owner),
    .owner_lock_o (olock)
  );

  // ---------------- reference model ----------------
  logic [N-1:0]  m_grant;
  logic [IW-1:0] m_owner;
  logic          m_lock;
  int            m_age [N];

  function automatic int ref_pick(input logic [N-1:0] r, input logic [1:0] pol,
                                  input int last, input logic [N-1:0] aged);
    logic [N-1:0] cand;
    if (pol == 2'b01) begin
      for (int s = 1; s <= N; s++) begin
        if (r[(last + s) % N]) return (last + s) % N;
      end
      return 0;
    end
    cand = r;
    if (pol == 2'b10 && (r & aged) != '0) cand = r & aged;
    for (int c = 0; c < N; c++) begin
      if (cand[c]) return c;
    end
    return 0;
  endfunction

  task automatic model_step();
    logic bnd, ho;
    int gi, nown, p;
    logic [N-1:0] aged;
    int nage [N];
    bnd = hready && (htrans == 2'b00 || blast);
    gi = 0;
    for (int k = 0; k < N; k++) if (m_grant[k]) gi = k;
    ho   = bnd && !m_lock && (gi != int'(m_owner));
    nown = ho ? gi : int'(m_owner);
    for (int k = 0; k < N; k++) begin
      aged[k] = (m_age[k] >= int'(limit));
      if (!req[k] || k == int'(m_owner)) nage[k] = 0;
      else if (m_age[k] < int'(limit))   nage[k] = m_age[k] + 1;
      else                               nage[k] = m_age[k];
    end
    p = ref_pick(req, policy, int'(m_owner), aged);
    m_grant = lock[nown] ? (N'(1) << nown) : (N'(1) << p);
    m_lock  = lock[nown];
    m_owner = IW'(nown);
    for (int k = 0; k < N; k++) m_age[k] = nage[k];
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_grant = N'(1);
      m_owner = '0;
      m_lock  = 1'b0;
      for (int k = 0; k < N; k++) m_age[k] = 0;
    end else begin
      model_step();
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input logic ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  logic [IW-1:0] prev_owner;
  logic [N-1:0]  prev_grant;
  int            waitc [N];

  task automatic cycle_check();
    string gtag;
    gtag = (policy == 2'b01) ? "R5" : (policy == 2'b10) ? "R6" :
           (policy == 2'b11) ? "R10" : "R4";
    chk(grant == m_grant, gtag, "grant", int'(grant), int'(m_grant));
    chk($countones(grant) == 1, "R2", "grant one-hot", int'(grant), 1);
    chk(owner == m_owner, "R7", "owner", int'(owner), int'(m_owner));
    chk(olock == m_lock, "R9", "owner lock", int'(olock), int'(m_lock));
    if (owner != prev_owner) begin
      chk(prev_grant[owner] == 1'b1, "R8", "grant before handover",
          int'(prev_grant), int'(N'(1) << owner));
      if (policy == 2'b01 && req[owner]) begin
        for (int i = 0; i < N; i++) begin
          if (i != int'(owner) && req[i]) begin
            waitc[i]++;
            chk(waitc[i] <= N - 1, "R5", "round-robin wait", waitc[i], N - 1);
          end
        end
      end
      waitc[owner] = 0;
    end
    for (int i = 0; i < N; i++) if (!req[i] || policy != 2'b01) waitc[i] = 0;
    prev_owner = owner;
    prev_grant = grant;
  endtask

  task automatic tick();
    @(negedge clk);
    cycle_check();
  endtask

  task automatic rand_drive();
    for (int i = 0; i < N; i++) begin
      if (!(policy == 2'b01 && req[i] && owner != IW'(i)))
        req[i] = ($urandom % 100) < 60;
      lock[i] = lock[i] ? (($urandom % 4) != 0) : (($urandom % 16) == 0);
    end
    htrans = 2'($urandom % 4);
    blast  = ($urandom % 3) == 0;
    hready = ($urandom % 5) != 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req = '0; lock = '0; htrans = 2'b00; blast = 1'b0;
    hready = 1'b1; policy = 2'b00; limit = AW'(3);
    for (int i = 0; i < N; i++) waitc[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(grant == 4'b0001, "R1", "reset grant", int'(grant), 1);
    chk(owner == 2'd0, "R1", "reset owner", int'(owner), 0);
    chk(olock == 1'b0, "R1", "reset lock", int'(olock), 0);
    prev_owner = '0;
    prev_grant = 4'b0001;
    rst_n = 1'b1;

    // R4 fixed priority, then R7 handover at idle boundary
    req = 4'b1100;
    tick();
    chk(grant == 4'b0100, "R4", "lowest requester granted", int'(grant), 4);
    chk(owner == 2'd0, "R8", "owner lags grant", int'(owner), 0);
    tick();
    chk(owner == 2'd2, "R7", "owner at boundary", int'(owner), 2);

    // R3 parking on master 0
    req = '0;
    tick();
    chk(grant == 4'b0001, "R3", "park grant", int'(grant), 1);
    tick();
    chk(owner == 2'd0, "R3", "park owner", int'(owner), 0);

    // R7 no handover mid-burst
    req = 4'b1000; htrans = 2'b10; blast = 1'b0;
    repeat (3) tick();
    chk(grant == 4'b1000, "R7", "grant moved ahead", int'(grant), 8);
    chk(owner == 2'd0, "R7", "owner held mid-burst", int'(owner), 0);
    blast = 1'b1;
    tick();
    chk(owner == 2'd3, "R7", "owner after last beat", int'(owner), 3);

    // R9 lock pins grant against a higher-priority requester
    htrans = 2'b00; lock = 4'b1000; req = 4'b1001;
    tick();
    chk(olock == 1'b1, "R9", "lock captured", int'(olock), 1);
    repeat (3) tick();
    chk(grant == 4'b1000, "R9", "grant pinned", int'(grant), 8);
    chk(owner == 2'd3, "R9", "owner pinned", int'(owner), 3);
    lock = '0;
    tick();
    chk(olock == 1'b0, "R9", "lock released", int'(olock), 0);
    chk(grant == 4'b0001, "R4", "grant after release", int'(grant), 1);
    tick();
    chk(owner == 2'd0, "R7", "owner after release", int'(owner), 0);

    // R10 spare policy code acts as fixed
    policy = 2'b11; req = 4'b0110;
    tick();
    chk(grant == 4'b0010, "R10", "spare code", int'(grant), 2);

    // R6 aging overtakes fixed priority
    policy = 2'b10; limit = AW'(2); req = '0;
    tick();
    tick();
    chk(owner == 2'd0, "R6", "setup owner", int'(owner), 0);
    req = 4'b1001; htrans = 2'b10; blast = 1'b0;
    tick();
    tick();
    chk(grant == 4'b0001, "R6", "not yet aged", int'(grant), 1);
    tick();
    chk(grant == 4'b1000, "R6", "aged requester wins", int'(grant), 8);

    // constrained random phases per policy
    for (int ph = 0; ph < 4; ph++) begin
      policy = 2'(ph);
      limit  = AW'($urandom % 8);
      for (int c = 0; c < 3000; c++) begin
        rand_drive();
        tick();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule